// File: doc/BRIEF.md
# Lockable Watchdog Timer

This block is a watchdog that counts cycles of the bus clock and fires when software fails to service it within a chosen interval. The interval is picked from sixteen power-of-two lengths by a 4-bit field. When the interval runs out, the block acts in one of two ways, chosen by software. It can raise a fast interrupt (FIQ) request that holds until serviced. It can instead send a short system reset pulse.

Software drives the block through a small register port with four word addresses. Writes are single-cycle strobes; reads are combinational. Three mechanisms stop a runaway program from silencing the watchdog. Counting needs an explicit enable. The count restarts only when a 16-bit key is written to the service address. A sticky lock freezes the configuration until the next system reset.

Top module: `wdog_top`

## Requirements
- R1: After reset, `fiq_o` and `sys_rst_o` are 0, and reads of address 0 (control) and address 3 (status) return 0.
- R2: While the control enable bit (address 0, bit 0) is 0, the counter stays at zero and no time-out occurs, however long the wait.
- R3: With period field value n in control bits [7:4], the time-out takes effect exactly 2^(PERIOD_BASE+n) clock edges after the edge that enabled or restarted the count.
- R4: With control bit 1 set to 1 (interrupt response), a time-out sets `fiq_o`. It stays 1 until a valid key is written to address 1.
- R5: Status bit 0 (address 3) is set by every time-out and cleared by a valid key write.
- R6: With control bit 1 set to 0 (reset response), a time-out drives `sys_rst_o` high for exactly PULSE_LEN cycles, and `fiq_o` stays 0.
- R7: Writing exactly SVC_KEY to address 1 restarts the count from zero.
- R8: Writing any value other than SVC_KEY to address 1 has no effect: the count, `fiq_o` and the status bit are unchanged.
- R9: Writing 1 in bit 0 of address 2 engages the lock, which shows as status bit 1. While it is engaged, writes to the control register are ignored.
- R10: The lock cannot be released by any register write. Only a system reset (`rst_ni` low) clears it.
- R11: If the period is shortened below the current count, a time-out follows on the next clock edge instead of the counter running on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock; the counter advances on it |
| rst_ni | input | 1 | Asynchronous active-low system reset |
| wr_en_i | input | 1 | Register write strobe, one cycle per write |
| addr_i | input | 2 | Register address: 0 control, 1 service, 2 lock, 3 status |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Combinational read data for `addr_i` |
| fiq_o | output | 1 | Fast interrupt request, held until serviced |
| sys_rst_o | output | 1 | System reset request pulse |

## Verification
The bench builds the block with PERIOD_BASE set to 2 and PULSE_LEN at its default of 4. This makes the four shortest periods last 4 to 32 cycles. At that length, edge-exact time-out checks, back-to-back reset pulses at the shortest period, and shortening the period in the middle of a count can all be reached within a few hundred cycles. Random runs mix period, response and wrong-key writes between exact timing checks.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    typedef enum logic [1:0] {
        REG_CTRL = 2'd0,
        REG_SVC  = 2'd1,
        REG_LOCK = 2'd2,
        REG_STAT = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [3:0] period;
        logic       fiq_mode;
        logic       enable;
    } wd_cfg_t;

endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
    import wdog_pkg::*;
#(
    parameter int          DW      = 16,
    parameter logic [15:0] SVC_KEY = 16'hC3A5
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          wr_en_i,
    input  logic [1:0]    addr_i,
    input  logic [DW-1:0] wdata_i,
    output wd_cfg_t       cfg_o,
    output logic          locked_o,
    output logic          svc_o
);

    typedef struct packed {
        wd_cfg_t cfg;
        logic    lock;
    } regs_state_t;

    regs_state_t st_d, st_q;

    always_comb begin
        st_d  = st_q;
        svc_o = wr_en_i && (reg_sel_e'(addr_i) == REG_SVC) && (wdata_i[15:0] == SVC_KEY);
        if (wr_en_i && reg_sel_e'(addr_i) == REG_CTRL && !st_q.lock) begin
            st_d.cfg.enable   = wdata_i[0];
            st_d.cfg.fiq_mode = wdata_i[1];
            st_d.cfg.period   = wdata_i[7:4];
        end
        if (wr_en_i && reg_sel_e'(addr_i) == REG_LOCK && wdata_i[0]) begin
            st_d.lock = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign cfg_o    = st_q.cfg;
    assign locked_o = st_q.lock;

    AST_LOCK_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.lock |=> st_q.lock); // R10
    AST_LOCK_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.lock |=> $stable(st_q.cfg)); // R9

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
    parameter int PERIOD_BASE = 16,
    localparam int CW         = PERIOD_BASE + 16
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       en_i,
    input  logic [3:0] period_i,
    input  logic       svc_i,
    output logic       tick_o
);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic [CW:0] limit;
    logic [CW:0] last;

    always_comb begin
        limit  = {{CW{1'b0}}, 1'b1} << (PERIOD_BASE + int'(period_i));
        last   = limit - {{CW{1'b0}}, 1'b1};
        tick_o = en_i && !svc_i && ({1'b0, st_q.cnt} >= last);
        st_d   = st_q;
        if (!en_i || svc_i || tick_o) st_d.cnt = '0;
        else                          st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> (st_q.cnt == '0)); // R2
    AST_TICK_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> (st_q.cnt == '0)); // R3
    AST_SVC_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
        svc_i |=> (st_q.cnt == '0)); // R7

endmodule

// File: rtl/wdog_resp.sv
module wdog_resp #(
    parameter int PULSE_LEN = 4,
    localparam int PW       = $clog2(PULSE_LEN + 1)
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic tick_i,
    input  logic fiq_mode_i,
    input  logic svc_i,
    output logic fiq_o,
    output logic sys_rst_o,
    output logic flag_o
);

    typedef struct packed {
        logic          fiq;
        logic          flag;
        logic [PW-1:0] pcnt;
    } resp_state_t;

    resp_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.pcnt != '0) st_d.pcnt = st_q.pcnt - 1'b1;
        if (tick_i) begin
            st_d.flag = 1'b1;
            if (fiq_mode_i) st_d.fiq  = 1'b1;
            else            st_d.pcnt = PW'(PULSE_LEN);
        end
        if (svc_i) begin
            st_d.fiq  = 1'b0;
            st_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign fiq_o     = st_q.fiq;
    assign flag_o    = st_q.flag;
    assign sys_rst_o = (st_q.pcnt != '0);

    AST_FIQ_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.fiq && !svc_i) |=> st_q.fiq); // R4
    AST_SVC_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        svc_i |=> (!st_q.fiq && !st_q.flag)); // R5
    AST_FLAG_ON_TIMEOUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_i && !svc_i) |=> st_q.flag); // R5
    AST_PULSE_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_i && !fiq_mode_i) |=> sys_rst_o); // R6

endmodule

// File: rtl/wdog_top.sv
module wdog_top
    import wdog_pkg::*;
#(
    parameter int          PERIOD_BASE = 16,
    parameter int          PULSE_LEN   = 4,
    parameter logic [15:0] SVC_KEY     = 16'hC3A5
) (
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        wr_en_i,
    input  logic [1:0]  addr_i,
    input  logic [15:0] wdata_i,
    output logic [15:0] rdata_o,
    output logic        fiq_o,
    output logic        sys_rst_o
);

    wd_cfg_t cfg;
    logic    locked;
    logic    svc;
    logic    tick;
    logic    flag;

    wdog_regs #(
        .DW      (16),
        .SVC_KEY (SVC_KEY)
    ) u_regs (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .wr_en_i  (wr_en_i),
        .addr_i   (addr_i),
        .wdata_i  (wdata_i),
        .cfg_o    (cfg),
        .locked_o (locked),
        .svc_o    (svc)
    );

    wdog_counter #(
        .PERIOD_BASE (PERIOD_BASE)
    ) u_counter (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .en_i     (cfg.enable),
        .period_i (cfg.period),
        .svc_i    (svc),
        .tick_o   (tick)
    );

    wdog_resp #(
        .PULSE_LEN (PULSE_LEN)
    ) u_resp (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .tick_i     (tick),
        .fiq_mode_i (cfg.fiq_mode),
        .svc_i      (svc),
        .fiq_o      (fiq_o),
        .sys_rst_o  (sys_rst_o),
        .flag_o     (flag)
    );

    always_comb begin
        case (reg_sel_e'(addr_i))
            REG_CTRL: rdata_o = {8'h00, cfg.period, 2'b00, cfg.fiq_mode, cfg.enable};
            REG_STAT: rdata_o = {14'h0000, locked, flag};
            default:  rdata_o = 16'h0000;
        endcase
    end

    AST_NO_TIMEOUT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !cfg.enable |-> !tick); // R2

endmodule

// File: tb/wdog_top_tb_top.sv
module wdog_top_tb_top;

    localparam int          BASE = 2;
    localparam int          PLEN = 4;
    localparam logic [15:0] KEY  = 16'hC3A5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [15:0] wdata = 16'h0000;
    logic [15:0] rdata;
    logic        fiq;
    logic        srst;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    wdog_top #(
        .PERIOD_BASE (BASE),
        .PULSE_LEN   (PLEN),
        .SVC_KEY     (KEY)
    ) dut_i (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .wr_en_i   (wr_en),
        .addr_i    (addr),
        .wdata_i   (wdata),
        .rdata_o   (rdata),
        .fiq_o     (fiq),
        .sys_rst_o (srst)
    );

    function automatic int lim_of(int n);
        return 1 << (BASE + n);
    endfunction

    function automatic logic exp_pulse(int k, int lim);
        return (k >= lim) && ((k % lim) < PLEN);
    endfunction

    function automatic logic [15:0] ctrl_word(int n, logic fm, logic en);
        return {8'h00, 4'(n), 2'b00, fm, en};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic steps(int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic wr(logic [1:0] a, logic [15:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; wdata = 16'h0000;
    endtask

    task automatic rd(logic [1:0] a, output logic [15:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        void'($urandom(32'd20240611));
        steps(3);
        rst_n = 1'b1;
        steps(1);

        // R1 reset state
        check("R1 fiq", 32'(fiq), 0);
        check("R1 sys_rst", 32'(srst), 0);
        rd(2'd0, v); check("R1 ctrl", 32'(v), 0);
        rd(2'd3, v); check("R1 status", 32'(v), 0);

        // R2 disabled: no time-out
        steps(150);
        check("R2 fiq", 32'(fiq), 0);
        check("R2 sys_rst", 32'(srst), 0);
        rd(2'd3, v); check("R2 status", 32'(v), 0);

        // R3/R4/R5 interrupt mode, n=1 -> 8 cycles
        wr(2'd0, ctrl_word(1, 1'b1, 1'b1));
        steps(lim_of(1) - 1);
        check("R3 before limit", 32'(fiq), 0);
        steps(1);
        check("R3 at limit", 32'(fiq), 1);
        rd(2'd3, v); check("R5 flag set", 32'(v[0]), 1);
        check("R6 no reset in fiq mode", 32'(srst), 0);
        steps(20);
        check("R4 fiq held", 32'(fiq), 1);
        wr(2'd1, 16'h1234);
        check("R8 wrong key keeps fiq", 32'(fiq), 1);
        rd(2'd3, v); check("R8 wrong key keeps flag", 32'(v[0]), 1);
        wr(2'd1, KEY);
        check("R4 key clears fiq", 32'(fiq), 0);
        rd(2'd3, v); check("R5 key clears flag", 32'(v[0]), 0);

        // R7 key restart mid-count
        steps(5);
        wr(2'd1, KEY);
        steps(lim_of(1) - 1);
        check("R7 restarted, not yet", 32'(fiq), 0);
        steps(1);
        check("R7 restarted time-out", 32'(fiq), 1);
        wr(2'd1, KEY);

        // R8 wrong key does not restart
        steps(3);
        wr(2'd1, KEY ^ 16'h0100);
        steps(3);
        check("R8 not restarted, before", 32'(fiq), 0);
        steps(1);
        check("R8 original time-out", 32'(fiq), 1);
        wr(2'd1, KEY);

        // R11 period shortened below count
        wr(2'd0, 16'h0000);
        wr(2'd0, ctrl_word(3, 1'b1, 1'b1));
        steps(19);
        wr(2'd0, ctrl_word(0, 1'b1, 1'b1));
        check("R11 not yet", 32'(fiq), 0);
        steps(1);
        check("R11 next-edge time-out", 32'(fiq), 1);
        wr(2'd0, 16'h0000);
        wr(2'd1, KEY);

        // R6 reset mode, n=1 -> 8 cycles
        wr(2'd0, ctrl_word(1, 1'b0, 1'b1));
        steps(lim_of(1) - 1);
        check("R6 before limit", 32'(srst), 0);
        steps(1);
        check("R6 pulse start", 32'(srst), 1);
        check("R6 fiq stays low", 32'(fiq), 0);
        steps(PLEN - 1);
        check("R6 pulse last", 32'(srst), 1);
        steps(1);
        check("R6 pulse end", 32'(srst), 0);
        rd(2'd3, v); check("R5 flag in reset mode", 32'(v[0]), 1);
        wr(2'd0, 16'h0000);
        wr(2'd1, KEY);

        // R9 lock
        wr(2'd0, ctrl_word(1, 1'b1, 1'b1));
        wr(2'd2, 16'h0001);
        rd(2'd3, v); check("R9 locked bit", 32'(v[1]), 1);
        wr(2'd0, 16'h0000);
        rd(2'd0, v); check("R9 ctrl frozen", 32'(v), 32'(ctrl_word(1, 1'b1, 1'b1)));
        wr(2'd1, KEY);
        steps(lim_of(1));
        check("R9 still enabled", 32'(fiq), 1);
        wr(2'd1, KEY);
        wr(2'd2, 16'h0000);
        rd(2'd3, v); check("R10 lock survives write", 32'(v[1]), 1);

        // R10 reset releases lock
        rst_n = 1'b0;
        steps(2);
        rst_n = 1'b1;
        steps(1);
        rd(2'd3, v); check("R10 lock cleared", 32'(v), 0);
        rd(2'd0, v); check("R10 ctrl cleared", 32'(v), 0);
        check("R1 fiq after reset", 32'(fiq), 0);

        // Random: period, response and stray wrong-key writes
        for (int it = 0; it < 12; it++) begin
            int n;
            logic fm;
            int lim;
            n   = int'($urandom % 4);
            fm  = 1'($urandom % 2);
            lim = lim_of(n);
            wr(2'd0, ctrl_word(n, fm, 1'b1));
            for (int k = 1; k <= lim + 5; k++) begin
                if (($urandom % 4) == 0) begin
                    wr_en = 1'b1; addr = 2'd1;
                    wdata = KEY ^ 16'(($urandom % 16'hFFFE) + 1);
                end
                @(negedge clk);
                wr_en = 1'b0;
                if (fm) begin
                    check("R3 R8 random fiq", 32'(fiq), 32'(k >= lim));
                    check("R4 random no pulse", 32'(srst), 0);
                end else begin
                    check("R6 R8 random pulse", 32'(srst), 32'(exp_pulse(k, lim)));
                    check("R6 random no fiq", 32'(fiq), 0);
                end
            end
            wr(2'd0, 16'h0000);
            wr(2'd1, KEY);
            steps(PLEN + 2);
            check("R4 random cleared fiq", 32'(fiq), 0);
            check("R6 random pulse done", 32'(srst), 0);
            rd(2'd3, v); check("R5 random flag cleared", 32'(v[0]), 0);
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule